// File: doc/BRIEF.md
# Hint-Directed Recency Stack Directory

This block is the tag directory of a fully associative cache whose entries are kept as an ordered recency stack. Position 0 is the most-recently-used end (top) and position DEPTH-1 is the least-recently-used end (bottom). Every valid entry sits above every invalid one, so an occupancy of n means that positions 0 to n-1 hold tags.

Each access brings a tag and a two-bit hint. The directory compares the tag with every valid entry at once and reports whether it hit. It then rearranges the stack according to the hint. A normal access promotes the tag to the top. A bypass access places or demotes the tag to the bottom. A trespass access evicts from the top and inserts there, which can leave the stack only partly full. Any tag pushed out is reported along with the new occupancy, and all results are registered one cycle after the access. One access is taken per clock, and each access sees the effect of the one before it. A set-associative cache uses one instance per set. Data storage, refill and the choice of hints are handled outside this block.

Top module: `hint_stack_dir`

## Requirements
- R1: After synchronous reset, hit, evict_valid and occupancy are 0 and every entry is invalid, so the first access that follows misses.
- R2: An access whose tag equals any valid entry raises hit in the cycle after the access. Otherwise hit stays low.
- R3: Normal hint (00), miss: the tag is written at the top and every other entry moves down one place. The bottom tag is evicted only if the stack was full, and occupancy grows by one otherwise.
- R4: Normal hint (00), hit at position h: the entries above h move down one place, the tag goes to the top, nothing is evicted and occupancy is unchanged.
- R5: Bypass hint (01), miss: if the stack is full, the bottom tag is evicted and replaced by the new tag. Otherwise the tag fills the first free position and occupancy grows by one. No other entry moves.
- R6: Bypass hint (01), hit at position h: the valid entries below h move up one place, the tag takes the lowest valid position, and nothing is evicted.
- R7: Trespass hint (10), miss: a non-empty stack loses its top tag, which is reported as evicted, and the new tag takes the top; occupancy is unchanged. An empty stack receives the tag at the top and its occupancy becomes 1.
- R8: Trespass hint (10), hit: a hit on the top entry changes nothing. A hit on any lower entry evicts the top tag, places the hit tag at the top, moves the valid entries below the hit position up one place, and reduces occupancy by one.
- R9: Hint 11 behaves exactly as the normal hint.
- R10: A cycle with access_valid low changes no entry. In the following cycle hit and evict_valid are 0 and occupancy is held.
- R11: evict_tag is 0 whenever evict_valid is 0. Valid entries always form a contiguous run from the top whose length equals occupancy, which never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| access_valid | input | 1 | An access is presented this cycle |
| access_tag | input | TW | Tag being accessed |
| access_hint | input | 2 | 00 normal, 01 bypass, 10 trespass, 11 normal |
| hit | output | 1 | Previous access hit |
| evict_valid | output | 1 | Previous access pushed a tag out |
| evict_tag | output | TW | Tag pushed out, 0 if none |
| occupancy | output | $clog2(DEPTH+1) | Number of valid entries |

## Verification
Some properties are checked by assertions on every cycle. The valid run must stay packed from the top and match occupancy. A normal access must not evict unless the stack is full, and a normal or bypass hit must never evict. A trespass access on a non-empty stack must not increase occupancy, and an idle cycle must leave the outputs quiet. The exact order of entries after each hint and hit position can only be shown by the bench scenarios. Each case is followed by a run of fresh normal misses, and the tags these push out reveal the complete stack order, bottom first. These results are compared with an arithmetic model of the rules.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    typedef enum logic [1:0] {
        HINT_NORMAL   = 2'b00,
        HINT_BYPASS   = 2'b01,
        HINT_TRESPASS = 2'b10,
        HINT_SPARE    = 2'b11
    } hint_e;

    typedef struct packed {
        hint_e mode;
        logic  hit;
    } acc_kind_t;

    // The spare code is folded onto normal handling.
    function automatic hint_e resolve_hint(input logic [1:0] raw);
        hint_e h;
        h = hint_e'(raw);
        if (h == HINT_SPARE) h = HINT_NORMAL;
        return h;
    endfunction

endpackage

// File: rtl/hsd_match.sv
module hsd_match #(
    parameter int DEPTH = 8,
    parameter int TW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][TW-1:0] tags,
    input  logic [DEPTH-1:0]         valid,
    input  logic [TW-1:0]            probe,
    output logic                     found,
    output logic [IW-1:0]            found_idx
);

    logic [DEPTH-1:0] match;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = valid[g] && (tags[g] == probe);
        end
    endgenerate

    assign found = |match;

    always_comb begin
        found_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) found_idx = IW'(i);
        end
    end

endmodule

// File: rtl/hsd_next.sv
module hsd_next
    import hsd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][TW-1:0] tags_q,
    input  logic [DEPTH-1:0]         valid_q,
    input  logic [CW-1:0]            count_q,
    input  acc_kind_t                kind,
    input  logic [IW-1:0]            hit_idx,
    input  logic [TW-1:0]            req_tag,
    output logic [DEPTH-1:0][TW-1:0] tags_d,
    output logic [DEPTH-1:0]         valid_d,
    output logic [CW-1:0]            count_d,
    output logic                     ev_d,
    output logic [TW-1:0]            ev_tag_d
);

    int cnt;
    int hidx;
    logic full;

    always_comb begin
        cnt      = int'(count_q);
        hidx     = int'(hit_idx);
        full     = (cnt == DEPTH);
        tags_d   = tags_q;
        valid_d  = valid_q;
        count_d  = count_q;
        ev_d     = 1'b0;
        ev_tag_d = '0;
        unique case (kind.mode)
            HINT_BYPASS: begin
                if (kind.hit) begin
                    for (int i = 0; i < DEPTH - 1; i++) begin
                        if (i >= hidx && i < cnt - 1) tags_d[i] = tags_q[i + 1];
                    end
                    if (cnt > 0) tags_d[cnt - 1] = req_tag;
                end else if (full) begin
                    ev_d              = 1'b1;
                    ev_tag_d          = tags_q[DEPTH - 1];
                    tags_d[DEPTH - 1] = req_tag;
                end else begin
                    tags_d[cnt]  = req_tag;
                    valid_d[cnt] = 1'b1;
                    count_d      = count_q + CW'(1);
                end
            end
            HINT_TRESPASS: begin
                if (kind.hit) begin
                    if (hidx != 0) begin
                        ev_d      = 1'b1;
                        ev_tag_d  = tags_q[0];
                        tags_d[0] = req_tag;
                        for (int i = 0; i < DEPTH - 1; i++) begin
                            if (i >= hidx && i < cnt - 1) tags_d[i] = tags_q[i + 1];
                        end
                        if (cnt > 1) begin
                            tags_d[cnt - 1]  = '0;
                            valid_d[cnt - 1] = 1'b0;
                        end
                        count_d = count_q - CW'(1);
                    end
                end else begin
                    if (cnt != 0) begin
                        ev_d     = 1'b1;
                        ev_tag_d = tags_q[0];
                    end else begin
                        valid_d[0] = 1'b1;
                        count_d    = CW'(1);
                    end
                    tags_d[0] = req_tag;
                end
            end
            default: begin
                if (kind.hit) begin
                    for (int i = 1; i < DEPTH; i++) begin
                        if (i <= hidx) tags_d[i] = tags_q[i - 1];
                    end
                end else begin
                    if (full) begin
                        ev_d     = 1'b1;
                        ev_tag_d = tags_q[DEPTH - 1];
                    end else begin
                        count_d = count_q + CW'(1);
                    end
                    for (int i = 1; i < DEPTH; i++) tags_d[i] = tags_q[i - 1];
                    valid_d = {valid_q[DEPTH-2:0], 1'b1};
                end
                tags_d[0] = req_tag;
            end
        endcase
    end

endmodule

// File: rtl/hint_stack_dir.sv
module hint_stack_dir
    import hsd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          access_valid,
    input  logic [TW-1:0] access_tag,
    input  logic [1:0]    access_hint,
    output logic          hit,
    output logic          evict_valid,
    output logic [TW-1:0] evict_tag,
    output logic [CW-1:0] occupancy
);

    logic [DEPTH-1:0][TW-1:0] tags_q, tags_d;
    logic [DEPTH-1:0]         valid_q, valid_d;
    logic [CW-1:0]            count_q, count_d;
    logic                     found;
    logic [IW-1:0]            found_idx;
    logic                     ev_d;
    logic [TW-1:0]            ev_tag_d;
    acc_kind_t                kind;

    hsd_match #(.DEPTH(DEPTH), .TW(TW)) u_match (
        .tags      (tags_q),
        .valid     (valid_q),
        .probe     (access_tag),
        .found     (found),
        .found_idx (found_idx)
    );

    assign kind.mode = resolve_hint(access_hint);
    assign kind.hit  = found;

    hsd_next #(.DEPTH(DEPTH), .TW(TW)) u_next (
        .tags_q   (tags_q),
        .valid_q  (valid_q),
        .count_q  (count_q),
        .kind     (kind),
        .hit_idx  (found_idx),
        .req_tag  (access_tag),
        .tags_d   (tags_d),
        .valid_d  (valid_d),
        .count_d  (count_d),
        .ev_d     (ev_d),
        .ev_tag_d (ev_tag_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tags_q      <= '0;
            valid_q     <= '0;
            count_q     <= '0;
            hit         <= 1'b0;
            evict_valid <= 1'b0;
            evict_tag   <= '0;
        end else if (access_valid) begin
            tags_q      <= tags_d;
            valid_q     <= valid_d;
            count_q     <= count_d;
            hit         <= found;
            evict_valid <= ev_d;
            evict_tag   <= ev_tag_d;
        end else begin
            hit         <= 1'b0;
            evict_valid <= 1'b0;
            evict_tag   <= '0;
        end
    end

    assign occupancy = count_q;

    // Checker-side mask of the positions that should be valid.
    logic [DEPTH:0] occ_mask;
    assign occ_mask = ({{DEPTH{1'b0}}, 1'b1} << count_q) - 1'b1;

    a_r11_packed_run: assert property (@(posedge clk) disable iff (rst)
        valid_q == occ_mask[DEPTH-1:0]);

    a_r11_occ_bound: assert property (@(posedge clk) disable iff (rst)
        int'(occupancy) <= DEPTH);

    a_r11_quiet_tag: assert property (@(posedge clk) disable iff (rst)
        !evict_valid |-> evict_tag == '0);

    a_r3_evict_only_full: assert property (@(posedge clk) disable iff (rst)
        access_valid && access_hint[1] == access_hint[0] && int'(occupancy) != DEPTH
        |=> !evict_valid);

    a_r4_hit_keeps_all: assert property (@(posedge clk) disable iff (rst)
        access_valid && access_hint != 2'b10 |=> !(hit && evict_valid));

    a_r7_no_growth: assert property (@(posedge clk) disable iff (rst)
        access_valid && access_hint == 2'b10 && occupancy != '0
        |=> occupancy <= $past(occupancy));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !access_valid |=> !hit && !evict_valid && occupancy == $past(occupancy));

endmodule

// File: tb/hint_stack_dir_test.sv
module hint_stack_dir_test;

    localparam int D  = 4;
    localparam int TW = 8;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          access_valid = 1'b0;
    logic [TW-1:0] access_tag = '0;
    logic [1:0]    access_hint = 2'b00;
    logic          hit;
    logic          evict_valid;
    logic [TW-1:0] evict_tag;
    logic [CW-1:0] occupancy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m [D];
    int mn = 0;

    always #4 clk = ~clk;

    hint_stack_dir #(.DEPTH(D), .TW(TW)) uut (
        .clk          (clk),
        .rst          (rst),
        .access_valid (access_valid),
        .access_tag   (access_tag),
        .access_hint  (access_hint),
        .hit          (hit),
        .evict_valid  (evict_valid),
        .evict_tag    (evict_tag),
        .occupancy    (occupancy)
    );

    task automatic compare(input string req, input bit eh, input bit ev, input int et, input int eo);
        checks++;
        if (hit !== eh || evict_valid !== ev || int'(evict_tag) != et || int'(occupancy) != eo) begin
            failures++;
            $display("FAIL %s: got hit=%0b ev=%0b tag=%0d occ=%0d, expected hit=%0b ev=%0b tag=%0d occ=%0d",
                     req, hit, evict_valid, evict_tag, occupancy, eh, ev, et, eo);
        end
    endtask

    // Reference rules of the directory, applied to the bench's own copy of the stack.
    task automatic model(input int t, input int hn, output bit eh, output bit ev, output int et,
                         output string req);
        int h;
        h = -1;
        for (int i = 0; i < mn; i++) if (m[i] == t) h = i;
        eh = (h >= 0);
        ev = 1'b0;
        et = 0;
        if (hn == 3) begin
            req = eh ? "R9 R4 R2" : "R9 R3";
            hn = 0;
        end else if (hn == 0) req = eh ? "R4 R2" : "R3";
        else if (hn == 1)     req = eh ? "R6 R2" : "R5";
        else                  req = eh ? "R8 R2" : "R7";
        if (hn == 0) begin
            if (eh) begin
                for (int i = h; i > 0; i--) m[i] = m[i-1];
            end else begin
                if (mn == D) begin
                    ev = 1'b1;
                    et = m[D-1];
                end
                for (int i = (mn == D) ? D - 1 : mn; i > 0; i--) m[i] = m[i-1];
                if (mn < D) mn++;
            end
            m[0] = t;
        end else if (hn == 1) begin
            if (eh) begin
                for (int i = h; i < mn - 1; i++) m[i] = m[i+1];
                m[mn-1] = t;
            end else if (mn == D) begin
                ev = 1'b1;
                et = m[D-1];
                m[D-1] = t;
            end else begin
                m[mn] = t;
                mn++;
            end
        end else begin
            if (eh) begin
                if (h != 0) begin
                    ev = 1'b1;
                    et = m[0];
                    m[0] = t;
                    for (int i = h; i < mn - 1; i++) m[i] = m[i+1];
                    mn--;
                end
            end else begin
                if (mn > 0) begin
                    ev = 1'b1;
                    et = m[0];
                end else mn = 1;
                m[0] = t;
            end
        end
        if (!ev) req = {req, " R11"};
    endtask

    task automatic access(input int t, input int hn);
        bit eh, ev;
        int et;
        string req;
        access_valid = 1'b1;
        access_tag   = TW'(t);
        access_hint  = 2'(hn);
        model(t, hn, eh, ev, et, req);
        @(negedge clk);
        compare(req, eh, ev, et, mn);
    endtask

    task automatic idle();
        access_valid = 1'b0;
        access_tag   = 8'hA5;
        access_hint  = 2'b10;
        @(negedge clk);
        compare("R10", 1'b0, 1'b0, 0, mn);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        access_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mn = 0;
        for (int i = 0; i < D; i++) m[i] = 0;
        compare("R1", 1'b0, 1'b0, 0, 0);
    endtask

    initial begin
        logic [15:0] lf;
        @(negedge clk);
        do_reset();
        access(7, 0);
        // Sweep every hint against every fill level and hit position (n means miss).
        for (int hn = 0; hn < 4; hn++) begin
            for (int n = 0; n <= D; n++) begin
                for (int p = 0; p <= n; p++) begin
                    do_reset();
                    for (int k = 0; k < n; k++) access(10 + k, 0);
                    access((p == n) ? 99 : 10 + p, hn);
                    idle();
                    // Fresh normal misses flush the stack, exposing its order bottom first.
                    for (int j = 0; j < 2 * D; j++) access(200 + j, 0);
                end
            end
        end
        // Pseudo-random mix over a small tag set, including idle cycles.
        do_reset();
        lf = 16'hACE1;
        for (int s = 0; s < 3000; s++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[15:13] == 3'b000) idle();
            else access(int'(lf[4:0]) % 6, int'(lf[9:8]));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got running, expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule